// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a queue of up to sixteen transfers held in on-chip memories, with no processor involvement between entries. Three 16-entry regions sit behind a single auto-incrementing data port: a transmit region, a receive region and a command region. Software selects a region and a starting index through a pointer register, fills the transmit words and per-entry command words, sets the index of the last entry, and writes the start bit.

The controller then shifts each entry in turn. For each entry it uses that entry's command word to decide which chip-select lines to drive, whether to use the programmed word length or a fixed 8 bits, and whether chip select stays asserted into the next entry. Received words are stored at the same index as the transmit word that produced them. When the final entry finishes, the start bit clears itself and a sticky completion flag is raised. Software clears the flag by writing 1 to it.

Serial clock polarity, sampling phase, word length and a clock divisor come from a mode register. While a queue runs, that register, the queue-control register and the start bit are locked.

Top module: `queued_spi_master`

## Requirements
- R1: After reset, every `cs_o` line is 1 (the inactive level bit QCTL[8] resets to 1), `sck_o` and `mosi_o` are 0, and MODE, RUN and STAT read 0.
- R2: PTR[5:4] selects a region (0 transmit, 1 receive, 2 command) and PTR[3:0] selects an index. Each DATA access (read or write) uses the selected entry, then advances the index by one, wrapping from 15 to 0 inside the same region.
- R3: Writing RUN[0]=1 while idle starts the queue only when MODE[15] is 1. With MODE[15]=0 the write has no effect.
- R4: The queue runs entries 0 through QCTL[3:0], in ascending order, then stops.
- R5: Every serial half period lasts max(MODE[7:0], 2) system clock cycles. Each entry opens with one half period in which chip select is asserted and `sck_o` is idle.
- R6: `sck_o` idles at MODE[9]. With MODE[8]=0, `miso_i` is sampled on the leading edge and `mosi_o` changes on the trailing edge. With MODE[8]=1 it is the other way round. Data goes out most significant bit first.
- R7: An entry whose command bit CMD[14] is 1 transfers MODE[13:10] bits (a value of 0 means 16). Otherwise the entry transfers 8 bits.
- R8: During an entry, each `cs_o` line whose bit in CMD[3:0] is set is driven to the inverse of QCTL[8]; all other lines sit at QCTL[8]. With CMD[15]=1, the next entry follows at once. With CMD[15]=0, all lines idle for one half period before the next entry.
- R9: The word received for entry i is stored right-aligned at receive index i.
- R10: When the last entry completes, STAT[0] sets and RUN[0] clears. Writing 1 to STAT[0] clears it; writing 0 leaves it unchanged.
- R11: While a queue runs, writes to MODE, QCTL and RUN are ignored.
- R12: The receive region is read-only from the data port. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register select: 0 MODE, 1 RUN, 2 QCTL, 3 STAT, 4 PTR, 5 DATA |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of the access |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
A corrupted sequencer state shows up at the pins almost at once. A wrong half-period count shifts the next `sck_o` edge within one half period. A wrong entry index or latched command word drives the wrong chip-select pattern or word length in the first cycle of the following entry. A wrong shift or sample decision flips `mosi_o` within one half period and leaves a wrong word in the receive region, which a read after completion exposes. The bench therefore predicts `cs_o`, `sck_o` and `mosi_o` for every cycle of every queue, with `miso_i` looped back inverted so the received words are known in advance.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP} seq_state_e;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_RUN  = 3'd1;
  localparam logic [2:0] A_QCTL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_PTR  = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;

  localparam int RGN_TX  = 0;
  localparam int RGN_RX  = 1;
  localparam int RGN_CMD = 2;
  localparam int N_RGN   = 3;

  localparam int MODE_EN   = 15;
  localparam int MODE_BITS = 10;
  localparam int MODE_CPOL = 9;
  localparam int MODE_CPHA = 8;
  localparam int QCTL_CSIV = 8;
  localparam int CMD_KEEP  = 15;
  localparam int CMD_USEB  = 14;
endpackage

// File: rtl/spi_entry_ram.sv
module spi_entry_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_a_i,
  output logic [WIDTH-1:0] rdata_a_o,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload;

  // divisor below 2 behaves as 2
  assign reload = (div_i < DIV_W'(2)) ? DIV_W'(1) : div_i - DIV_W'(1);
  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= reload;
    else                          cnt_q <= cnt_q - DIV_W'(1);
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int W     = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     tx_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [W-1:0]     rx_o,
  output logic [W-1:0]     rx_next_o
);
  logic [W-1:0]     tx_q, rx_q;
  logic [CNT_W-1:0] lsh;

  assign lsh       = CNT_W'(W) - nbits_i;
  assign mosi_o    = tx_q[W-1];
  assign rx_o      = rx_q;
  assign rx_next_o = {rx_q[W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= tx_i << lsh;
      rx_q <= '0;
    end else begin
      if (shift_i)  tx_q <= {tx_q[W-2:0], 1'b0};
      if (sample_i) rx_q <= rx_next_o;
    end
  end
endmodule

// File: rtl/queued_spi_master.sv
module queued_spi_master
  import qspi_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int CS_N   = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [CS_N-1:0]   cs_o
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BITS_W = $clog2(DATA_W);
  localparam int HALF_W = $clog2(2 * DATA_W);

  // configuration
  logic              en_q, cpol_q, cpha_q, cs_idle_q;
  logic [BITS_W-1:0] mbits_q;
  logic [DIV_W-1:0]  div_q;
  logic [IDX_W-1:0]  last_q;
  logic [1:0]        ptr_rgn_q;
  logic [IDX_W-1:0]  ptr_idx_q;

  // sequencer
  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [HALF_W-1:0] half_q, nbits_q, nb_new;
  logic              keep_q, go_q, done_q;
  logic [CS_N-1:0]   csel_q;

  logic wr, rd, idle, go_accept, tick;
  logic edge_now, last_half, do_sample, do_shift, entry_end, is_last, load, in_entry;
  logic [IDX_W-1:0]  eng_rd_idx;
  logic [DATA_W-1:0] bus_rd [N_RGN];
  logic [DATA_W-1:0] eng_rd [N_RGN];
  logic [DATA_W-1:0] rx_q, rx_next, rx_wdata, data_rd, mode_rd, qctl_rd;
  logic              sh_mosi;

  assign wr        = bus_req_i & bus_we_i;
  assign rd        = bus_req_i & ~bus_we_i;
  assign idle      = (state_q == ST_IDLE);
  assign go_accept = wr && bus_addr_i == A_RUN && bus_wdata_i[0] && en_q && idle;

  // ---------------- register file ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      mbits_q   <= '0;
      div_q     <= '0;
      last_q    <= '0;
      cs_idle_q <= 1'b1;
      ptr_rgn_q <= '0;
      ptr_idx_q <= '0;
    end else begin
      if (wr && idle && bus_addr_i == A_MODE) begin
        en_q    <= bus_wdata_i[MODE_EN];
        mbits_q <= bus_wdata_i[MODE_BITS +: BITS_W];
        cpol_q  <= bus_wdata_i[MODE_CPOL];
        cpha_q  <= bus_wdata_i[MODE_CPHA];
        div_q   <= bus_wdata_i[DIV_W-1:0];
      end
      if (wr && idle && bus_addr_i == A_QCTL) begin
        last_q    <= bus_wdata_i[IDX_W-1:0];
        cs_idle_q <= bus_wdata_i[QCTL_CSIV];
      end
      if (wr && bus_addr_i == A_PTR) begin
        ptr_rgn_q <= bus_wdata_i[IDX_W +: 2];
        ptr_idx_q <= bus_wdata_i[IDX_W-1:0];
      end else if (bus_req_i && bus_addr_i == A_DATA) begin
        ptr_idx_q <= ptr_idx_q + IDX_W'(1);
      end
    end
  end

  // ---------------- entry memories ----------------
  for (genvar g = 0; g < N_RGN; g++) begin : g_ram
    logic              we;
    logic [IDX_W-1:0]  wa;
    logic [DATA_W-1:0] wd;
    if (g == RGN_RX) begin : g_eng
      assign we = entry_end;
      assign wa = idx_q;
      assign wd = rx_wdata;
    end else begin : g_bus
      assign we = wr && bus_addr_i == A_DATA && ptr_rgn_q == 2'(g);
      assign wa = ptr_idx_q;
      assign wd = bus_wdata_i;
    end
    spi_entry_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_ram (
      .clk_i    (clk_i),
      .we_i     (we),
      .waddr_i  (wa),
      .wdata_i  (wd),
      .raddr_a_i(ptr_idx_q),
      .rdata_a_o(bus_rd[g]),
      .raddr_b_i(eng_rd_idx),
      .rdata_b_o(eng_rd[g])
    );
  end

  always_comb begin
    case (ptr_rgn_q)
      2'd0:    data_rd = bus_rd[RGN_TX];
      2'd1:    data_rd = bus_rd[RGN_RX];
      2'd2:    data_rd = bus_rd[RGN_CMD];
      default: data_rd = '0;
    endcase
  end

  assign mode_rd = DATA_W'({en_q, 1'b0, mbits_q, cpol_q, cpha_q, div_q});
  assign qctl_rd = DATA_W'({cs_idle_q, 8'(last_q)});

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        A_MODE:  bus_rdata_o = mode_rd;
        A_RUN:   bus_rdata_o = DATA_W'(go_q);
        A_QCTL:  bus_rdata_o = qctl_rd;
        A_STAT:  bus_rdata_o = DATA_W'(done_q);
        A_PTR:   bus_rdata_o = DATA_W'({ptr_rgn_q, ptr_idx_q});
        A_DATA:  bus_rdata_o = data_rd;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  // ---------------- timing and shifting ----------------
  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(go_accept),
    .div_i    (div_q),
    .tick_o   (tick)
  );

  assign edge_now  = (state_q == ST_SHIFT) && tick;
  assign last_half = half_q == HALF_W'({nbits_q[HALF_W-2:0], 1'b0} - 1'b1);
  assign do_sample = edge_now && (half_q[0] == cpha_q);
  assign do_shift  = edge_now && (half_q[0] != cpha_q) && (half_q != '0) && !last_half;
  assign entry_end = edge_now && last_half;
  assign is_last   = (idx_q == last_q);
  assign load      = go_accept || (entry_end && !is_last && keep_q)
                   || (state_q == ST_GAP && tick);
  assign eng_rd_idx = idle ? '0 : idx_q + IDX_W'(1);
  assign rx_wdata   = do_sample ? rx_next : rx_q;

  always_comb begin
    if (!eng_rd[RGN_CMD][CMD_USEB]) nb_new = HALF_W'(8);
    else if (mbits_q == '0)         nb_new = HALF_W'(DATA_W);
    else                            nb_new = HALF_W'(mbits_q);
  end

  spi_bit_shifter #(.W(DATA_W), .CNT_W(HALF_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .tx_i     (eng_rd[RGN_TX]),
    .nbits_i  (nb_new),
    .shift_i  (do_shift),
    .sample_i (do_sample),
    .miso_i   (miso_i),
    .mosi_o   (sh_mosi),
    .rx_o     (rx_q),
    .rx_next_o(rx_next)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      half_q  <= '0;
      nbits_q <= HALF_W'(8);
      keep_q  <= 1'b0;
      csel_q  <= '0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (load) begin
        keep_q  <= eng_rd[RGN_CMD][CMD_KEEP];
        csel_q  <= eng_rd[RGN_CMD][CS_N-1:0];
        nbits_q <= nb_new;
      end
      if (entry_end && is_last)                            done_q <= 1'b1;
      else if (wr && bus_addr_i == A_STAT && bus_wdata_i[0]) done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go_accept) begin
          state_q <= ST_LEAD;
          idx_q   <= '0;
          go_q    <= 1'b1;
        end
        ST_LEAD: if (tick) begin
          state_q <= ST_SHIFT;
          half_q  <= '0;
        end
        ST_SHIFT: if (tick) begin
          if (!last_half) begin
            half_q <= half_q + HALF_W'(1);
          end else if (is_last) begin
            state_q <= ST_IDLE;
            go_q    <= 1'b0;
          end else if (keep_q) begin
            state_q <= ST_LEAD;
            idx_q   <= idx_q + IDX_W'(1);
          end else begin
            state_q <= ST_GAP;
          end
        end
        ST_GAP: if (tick) begin
          state_q <= ST_LEAD;
          idx_q   <= idx_q + IDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- pins ----------------
  assign in_entry = (state_q == ST_LEAD) || (state_q == ST_SHIFT);
  assign sck_o    = cpol_q ^ ((state_q == ST_SHIFT) & half_q[0]);
  assign mosi_o   = in_entry & sh_mosi;

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    assign cs_o[i] = (in_entry && csel_q[i]) ? ~cs_idle_q : cs_idle_q;
  end
endmodule

// File: rtl/queued_spi_master_chk.sv
module queued_spi_master_chk
  import qspi_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16,
  parameter int CS_N   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input seq_state_e        state_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [IDX_W-1:0]  last_i,
  input logic              go_i,
  input logic              done_i,
  input logic              tick_i,
  input logic              sck_i,
  input logic              cpol_i,
  input logic [CS_N-1:0]   cs_i,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [2:0]        bus_addr_i,
  input logic [DATA_W-1:0] mode_i,
  input logic [DATA_W-1:0] qctl_i
);
  p_sck_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != ST_SHIFT |-> sck_i == cpol_i);

  p_half_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  p_idx_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != ST_IDLE |-> idx_i <= last_i);

  p_done_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(state_i == ST_SHIFT) && state_i == ST_IDLE);

  p_go_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(go_i) |-> done_i);

  p_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && (bus_addr_i == A_MODE || bus_addr_i == A_QCTL)
     && state_i != ST_IDLE) |=> $stable(mode_i) && $stable(qctl_i));

  p_cs_steady_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SHIFT && $past(state_i == ST_SHIFT)) |-> $stable(cs_i));
endmodule

bind queued_spi_master queued_spi_master_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .CS_N(CS_N)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state_i   (state_q),
  .idx_i     (idx_q),
  .last_i    (last_q),
  .go_i      (go_q),
  .done_i    (done_q),
  .tick_i    (tick),
  .sck_i     (sck_o),
  .cpol_i    (cpol_q),
  .cs_i      (cs_o),
  .bus_req_i (bus_req_i),
  .bus_we_i  (bus_we_i),
  .bus_addr_i(bus_addr_i),
  .mode_i    (mode_rd),
  .qctl_i    (qctl_rd)
);

// File: tb/queued_spi_master_test.sv
module queued_spi_master_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_MODE = 0, A_RUN = 1, A_QCTL = 2, A_STAT = 3, A_PTR = 4, A_DATA = 5;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0, miso;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        sck, mosi;
  logic [3:0]  cs;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model configuration
  logic [15:0] tx_m [16];
  logic [15:0] cmd_m [16];
  int cpol_m, cpha_m, div_m, mbits_m, last_m, csiv_m;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign miso = ~mosi;

  queued_spi_master uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_o(cs)
  );

  task automatic expect_val(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [15:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [15:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic pins(string tag, logic [3:0] ecs, logic esck, logic emosi);
    @(negedge clk);
    n_chk++;
    if (cs !== ecs || sck !== esck || mosi !== emosi) begin
      n_fail++;
      $display("FAIL %s cs/sck/mosi act=%h/%b/%b exp=%h/%b/%b",
               tag, cs, sck, mosi, ecs, esck, emosi);
    end
  endtask

  function automatic int half_cycles();
    return div_m < 2 ? 2 : div_m;
  endfunction

  function automatic int bits_of(int e);
    if (!cmd_m[e][14]) return 8;
    return mbits_m == 0 ? 16 : mbits_m;
  endfunction

  function automatic logic [3:0] cs_idle();
    return csiv_m ? 4'hF : 4'h0;
  endfunction

  function automatic logic [3:0] cs_act(int e);
    return csiv_m ? ~cmd_m[e][3:0] : cmd_m[e][3:0];
  endfunction

  // expected pin waveform of one whole queue
  task automatic run_queue();
    int h = half_cycles();
    for (int e = 0; e <= last_m; e++) begin
      int b = bits_of(e);
      for (int c = 0; c < h; c++)
        pins("R5 R8 lead", cs_act(e), cpol_m[0], tx_m[e][b-1]);
      for (int k = 0; k < 2 * b; k++) begin
        int bi = cpha_m ? (k == 0 ? 0 : (k - 1) / 2) : k / 2;
        for (int c = 0; c < h; c++)
          pins("R4 R6 R7 shift", cs_act(e), cpol_m[0] ^ k[0], tx_m[e][b-1-bi]);
      end
      if (e != last_m && !cmd_m[e][15])
        for (int c = 0; c < h; c++) pins("R8 gap", cs_idle(), cpol_m[0], 1'b0);
    end
    pins("R4 stop", cs_idle(), cpol_m[0], 1'b0);
  endtask

  task automatic check_done_and_rx();
    logic [15:0] d;
    bus_rd(A_STAT, d); expect_val("R10 flag set", d, 16'h1);
    bus_rd(A_RUN, d);  expect_val("R10 run cleared", d, 16'h0);
    bus_wr(A_PTR, 16'h0010);
    for (int e = 0; e <= last_m; e++) begin
      int b = bits_of(e);
      logic [15:0] m = 16'((32'h1 << b) - 1);
      bus_rd(A_DATA, d);
      expect_val($sformatf("R9 rx entry %0d", e), d, ~tx_m[e] & m);
    end
  endtask

  task automatic load_queue();
    bus_wr(A_PTR, 16'h0000);
    for (int e = 0; e <= last_m; e++) bus_wr(A_DATA, tx_m[e]);
    bus_wr(A_PTR, 16'h0020);
    for (int e = 0; e <= last_m; e++) bus_wr(A_DATA, cmd_m[e]);
  endtask

  task automatic set_mode(int en);
    bus_wr(A_MODE, 16'(en << 15 | mbits_m << 10 | cpol_m << 9 | cpha_m << 8 | div_m));
    bus_wr(A_QCTL, 16'(csiv_m << 8 | last_m));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    pins("R1 reset pins", 4'hF, 1'b0, 1'b0);
    bus_rd(A_MODE, d); expect_val("R1 mode", d, 16'h0);
    bus_rd(A_RUN, d);  expect_val("R1 run", d, 16'h0);
    bus_rd(A_STAT, d); expect_val("R1 stat", d, 16'h0);
    bus_rd(A_QCTL, d); expect_val("R1 qctl", d, 16'h0100);

    // R3 start ignored with master enable clear
    bus_wr(A_RUN, 16'h1);
    for (int i = 0; i < 4; i++) pins("R3 disabled start", 4'hF, 1'b0, 1'b0);
    bus_rd(A_RUN, d); expect_val("R3 run stays 0", d, 16'h0);

    // queue A: mode 0, divisor 1 -> 2, three 8-bit entries
    cpol_m = 0; cpha_m = 0; div_m = 1; mbits_m = 0; last_m = 2; csiv_m = 1;
    tx_m[0] = 16'h00A5; tx_m[1] = 16'h003C; tx_m[2] = 16'h000F;
    cmd_m[0] = 16'h8001; cmd_m[1] = 16'h0002; cmd_m[2] = 16'h0004;
    load_queue();
    set_mode(1);
    bus_wr(A_RUN, 16'h1);
    run_queue();
    check_done_and_rx();

    // R2 region select and index wrap
    bus_wr(A_PTR, 16'h0020);
    bus_rd(A_DATA, d); expect_val("R2 cmd region 0", d, 16'h8001);
    bus_rd(A_DATA, d); expect_val("R2 cmd region 1", d, 16'h0002);
    bus_wr(A_PTR, 16'h000F);
    bus_wr(A_DATA, 16'h1111);
    bus_wr(A_DATA, 16'h2222);
    bus_wr(A_PTR, 16'h000F);
    bus_rd(A_DATA, d); expect_val("R2 tx index 15", d, 16'h1111);
    bus_rd(A_DATA, d); expect_val("R2 wrap to index 0", d, 16'h2222);

    // R10 write-one-to-clear
    bus_wr(A_STAT, 16'h0);
    bus_rd(A_STAT, d); expect_val("R10 write 0 keeps flag", d, 16'h1);
    bus_wr(A_STAT, 16'h1);
    bus_rd(A_STAT, d); expect_val("R10 write 1 clears flag", d, 16'h0);

    // queue B: mode 3, divisor 3, 12-bit single entry, active-high select; R11 writes while busy
    cpol_m = 1; cpha_m = 1; div_m = 3; mbits_m = 12; last_m = 0; csiv_m = 0;
    tx_m[0] = 16'h0ABC; cmd_m[0] = 16'h4003;
    load_queue();
    set_mode(1);
    bus_wr(A_RUN, 16'h1);
    fork
      run_queue();
      begin
        repeat (6) @(negedge clk);
        bus_wr(A_MODE, 16'h8002);
        bus_wr(A_QCTL, 16'h0105);
        bus_wr(A_RUN, 16'h1);
      end
    join
    for (int i = 0; i < 4; i++) pins("R11 no restart", 4'h0, 1'b1, 1'b0);
    bus_rd(A_MODE, d); expect_val("R11 mode locked", d, 16'hB303);
    bus_rd(A_QCTL, d); expect_val("R11 qctl locked", d, 16'h0000);
    check_done_and_rx();
    bus_wr(A_STAT, 16'h1);

    // R12 receive region read-only
    bus_wr(A_PTR, 16'h0010);
    bus_wr(A_DATA, 16'hFFFF);
    bus_wr(A_PTR, 16'h0010);
    bus_rd(A_DATA, d); expect_val("R12 rx unchanged", d, 16'h0543);

    // queue C: all 16 entries, 16-bit mixed with 8-bit, divisor 2, mode 2
    cpol_m = 1; cpha_m = 0; div_m = 2; mbits_m = 0; last_m = 15; csiv_m = 1;
    for (int e = 0; e < 16; e++) begin
      tx_m[e]  = 16'(e * 16'h1111) ^ 16'h05A3;
      cmd_m[e] = 16'(((e % 3 != 2) ? 16'h8000 : 16'h0) | (e[0] ? 16'h4000 : 16'h0) | (1 << (e % 4)));
    end
    load_queue();
    set_mode(1);
    bus_wr(A_RUN, 16'h1);
    run_queue();
    check_done_and_rx();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule